// File: doc/BRIEF.md
# Fuse Array Burst Read Controller

This block lets software read a one-time-programmable fuse array of 1024 bytes through a small 32-bit register bus. Software sets the access timing in a configuration register. It then writes a control word that holds a byte address and a read-enable bit. The block drives the fuse array through one timed access and captures a whole 32-byte row into eight data registers. It then raises a done flag, which software polls and which can also drive an interrupt line.

The sequencer has three states. `ST_IDLE` waits for an accepted start. `ST_SETUP` drives address and enable with the strobe low while a down-counter loaded from the setup-adjust field runs out. `ST_STROBE` holds the strobe high while a counter loaded from the strobe field plus three runs out. The transitions are as follows. IDLE goes to SETUP on an accepted start. SETUP stays in SETUP while its counter is non-zero and goes to STROBE when the counter reaches zero. STROBE stays in STROBE while its counter is non-zero. When the STROBE counter reaches zero, the state returns to IDLE, and in that same edge the row is captured and done is set.

Register offsets, all word-aligned:
- 0x00: control.
- 0x04: configuration.
- 0x08: status.
- 0x0C + 4·n: data word n.

Reads of any other offset return zero, and writes to any other offset are ignored. Programming of fuses is not supported. The program-enable, write-enable, length and write-timing fields are stored and read back but have no effect.

Top module: `fuse_burst_reader`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, and `fuse_en` and `fuse_strobe` are 0.
- R2: A write to control (offset 0x00) with bit 0 set, made while no access is in progress, starts an access. In the next cycle status bit 0 (done) reads 0 and `fuse_addr` equals the row index (control bits 30:26) times 16, which is the 32-byte-aligned byte address in 16-bit units.
- R3: After an accepted start, `fuse_en` is high and `fuse_strobe` is low for setup+1 cycles, where setup is configuration bits 23:20. `fuse_addr` stays stable while `fuse_en` is high.
- R4: `fuse_strobe` then stays high for strobe+4 cycles, where strobe is configuration bits 19:16. `fuse_en` falls together with it, so the access lasts setup+5+strobe cycles.
- R5: When the access ends, data word n takes `fuse_rdata[32n+31:32n]`, and done is set in the same edge. Byte b of the row sits at `fuse_rdata[8b+7:8b]`, so byte 0 lands in bits 7:0 of data word 0.
- R6: Done stays set, and the data words keep their values, until the next accepted start. This holds across writes that do not start an access.
- R7: A control write while an access is in progress is ignored. This includes a write in the final cycle of an access. The control read-back, the address and the timing are unchanged.
- R8: `irq` equals done AND configuration bit 31.
- R9: Control and configuration read back the last value accepted. A control write with bit 0 clear stores the value but starts no access. Status bit 1 always reads 0.
- R10: The setup and strobe counts are taken when an access starts. A configuration write during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| irq | output | 1 | Completion interrupt |
| fuse_addr | output | 9 | Fuse array address, 16-bit units |
| fuse_en | output | 1 | Fuse array enable for the whole access |
| fuse_strobe | output | 1 | Fuse array read strobe |
| fuse_rdata | input | 256 | One 32-byte row from the fuse array |

## Verification
The end of an access and a new control write can fall on the same clock edge: the sequencer leaves `ST_STROBE` and sets done just as software writes a fresh start. The bench provokes this by counting cycles from a start with setup 1 and strobe 1 and holding a control write across exactly the seventh edge. It judges the result by the control read-back staying unchanged, done reading 1, and `fuse_en` staying low in the following cycle. It then issues the same write one cycle later and expects it to be accepted. A second overlap is a configuration write during a long access, which the per-cycle reference model checks against the timing taken at the start.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    localparam int REG_W = 32;

    // register offsets
    localparam int OFF_CTRL  = 0;
    localparam int OFF_CFG   = 4;
    localparam int OFF_STAT  = 8;
    localparam int OFF_DATA0 = 12;

    // control fields
    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_ADDR_LSB = 21;

    // configuration fields
    localparam int CFG_IE_BIT      = 31;
    localparam int CFG_SETUP_LSB   = 20;
    localparam int CFG_STROBE_LSB  = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE
    } rd_state_e;

endpackage

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int ADJ_W = 4,
    parameter int STR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ADJ_W-1:0] setup_cnt,
    input  logic [STR_W-1:0] strobe_cnt,
    output logic             busy,
    output logic             fuse_en,
    output logic             fuse_strobe,
    output logic             capture
);

    localparam int CNT_W = ((ADJ_W > STR_W) ? ADJ_W : STR_W) + 2;

    rd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [STR_W-1:0] str_q;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)    state_d = ST_SETUP;
            ST_SETUP:  if (cnt_zero) state_d = ST_STROBE;
            ST_STROBE: if (cnt_zero) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // phase counter and strobe count snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            str_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q <= CNT_W'(setup_cnt);
                        str_q <= strobe_cnt;
                    end
                end
                ST_SETUP: begin
                    if (cnt_zero) cnt_q <= CNT_W'(str_q) + CNT_W'(3);
                    else          cnt_q <= cnt_q - CNT_W'(1);
                end
                ST_STROBE: begin
                    if (!cnt_zero) cnt_q <= cnt_q - CNT_W'(1);
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy        = 1'b0;
        fuse_en     = 1'b0;
        fuse_strobe = 1'b0;
        capture     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP: begin
                busy    = 1'b1;
                fuse_en = 1'b1;
            end
            ST_STROBE: begin
                busy        = 1'b1;
                fuse_en     = 1'b1;
                fuse_strobe = 1'b1;
                capture     = cnt_zero;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fuse_data_bank.sv
module fuse_data_bank
    import fuse_rd_pkg::*;
#(
    parameter int WORDS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic [WORDS*REG_W-1:0] row_in,
    output logic [WORDS*REG_W-1:0] words_out
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [REG_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (capture) begin
                word_q <= row_in[g*REG_W +: REG_W];
            end
        end
        assign words_out[g*REG_W +: REG_W] = word_q;
    end

endmodule

// File: rtl/fuse_burst_reader.sv
module fuse_burst_reader
    import fuse_rd_pkg::*;
#(
    parameter int BYTE_AW = 10,
    parameter int FUSE_AW = 9,
    parameter int WORDS   = 8,
    parameter int ADJ_W   = 4,
    parameter int STR_W   = 4,
    parameter int REG_AW  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic                   reg_wen,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    output logic                   irq,
    output logic [FUSE_AW-1:0]     fuse_addr,
    output logic                   fuse_en,
    output logic                   fuse_strobe,
    input  logic [WORDS*REG_W-1:0] fuse_rdata
);

    localparam int ROW_BYTES = WORDS * (REG_W / 8);
    localparam int ROW_LSB   = $clog2(ROW_BYTES);
    localparam int ROW_W     = BYTE_AW - ROW_LSB;
    localparam int PAD_W     = FUSE_AW - ROW_W;
    localparam int ROW_HI    = CTRL_ADDR_LSB + BYTE_AW - 1;
    localparam int ROW_LO    = CTRL_ADDR_LSB + ROW_LSB;

    logic [REG_W-1:0]       ctrl_q, cfg_q;
    logic                   rd_done_q;
    logic [FUSE_AW-1:0]     fuse_addr_q;
    logic                   busy, capture, start;
    logic                   hit_ctrl, hit_cfg;
    logic [WORDS*REG_W-1:0] words;

    assign hit_ctrl = reg_wen && (reg_addr == REG_AW'(OFF_CTRL));
    assign hit_cfg  = reg_wen && (reg_addr == REG_AW'(OFF_CFG));
    assign start    = hit_ctrl && !busy && reg_wdata[CTRL_GO_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            cfg_q       <= '0;
            fuse_addr_q <= '0;
            rd_done_q   <= 1'b0;
        end else begin
            if (hit_ctrl && !busy) ctrl_q <= reg_wdata;
            if (hit_cfg)           cfg_q  <= reg_wdata;
            if (start) begin
                fuse_addr_q <= {reg_wdata[ROW_HI:ROW_LO], {PAD_W{1'b0}}};
                rd_done_q   <= 1'b0;
            end else if (capture) begin
                rd_done_q   <= 1'b1;
            end
        end
    end

    fuse_rd_seq #(
        .ADJ_W (ADJ_W),
        .STR_W (STR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .setup_cnt   (cfg_q[CFG_SETUP_LSB +: ADJ_W]),
        .strobe_cnt  (cfg_q[CFG_STROBE_LSB +: STR_W]),
        .busy        (busy),
        .fuse_en     (fuse_en),
        .fuse_strobe (fuse_strobe),
        .capture     (capture)
    );

    fuse_data_bank #(
        .WORDS (WORDS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .row_in    (fuse_rdata),
        .words_out (words)
    );

    assign fuse_addr = fuse_addr_q;
    assign irq       = rd_done_q && cfg_q[CFG_IE_BIT];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(OFF_CTRL)) reg_rdata = ctrl_q;
        if (reg_addr == REG_AW'(OFF_CFG))  reg_rdata = cfg_q;
        if (reg_addr == REG_AW'(OFF_STAT)) reg_rdata = REG_W'(rd_done_q);
        for (int i = 0; i < WORDS; i++) begin
            if (reg_addr == REG_AW'(OFF_DATA0 + 4 * i)) begin
                reg_rdata = words[i*REG_W +: REG_W];
            end
        end
    end

endmodule

// File: rtl/fuse_burst_reader_chk.sv
module fuse_burst_reader_chk #(
    parameter int FUSE_AW = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fuse_en,
    input logic               fuse_strobe,
    input logic [FUSE_AW-1:0] fuse_addr,
    input logic               irq,
    input logic               rd_done
);

    p_strobe_in_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_strobe |-> fuse_en);

    p_strobe_ends_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_strobe) |-> !fuse_en);

    p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fuse_en) |-> !fuse_strobe);

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_en && $past(fuse_en)) |-> $stable(fuse_addr));

    p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_en) |-> rd_done);

    p_done_clear_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_en |-> !rd_done);

    p_irq_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rd_done);

endmodule

bind fuse_burst_reader fuse_burst_reader_chk #(.FUSE_AW(FUSE_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fuse_en     (fuse_en),
    .fuse_strobe (fuse_strobe),
    .fuse_addr   (fuse_addr),
    .irq         (irq),
    .rd_done     (rd_done_q)
);

// File: tb/fuse_burst_reader_test.sv
`timescale 1ns/1ps
module fuse_burst_reader_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   reg_addr = '0;
    logic         reg_wen = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq;
    logic [8:0]   fuse_addr;
    logic         fuse_en;
    logic         fuse_strobe;
    logic [255:0] fuse_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fuse_burst_reader uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .fuse_addr(fuse_addr), .fuse_en(fuse_en), .fuse_strobe(fuse_strobe),
        .fuse_rdata(fuse_rdata)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(((a * 29) + (a >> 2)) ^ 8'hA5);
    endfunction

    function automatic logic [31:0] exp_word(input int row, input int w);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) v[8*k +: 8] = pat(row * 32 + 4 * w + k);
        return v;
    endfunction

    // behavioural fuse array
    always @* begin
        for (int b = 0; b < 32; b++)
            fuse_rdata[8*b +: 8] = fuse_en ? pat(int'(fuse_addr) * 2 + b) : 8'h00;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model
    bit          m_busy = 0, m_done = 0, was_busy;
    int          m_el = 0, m_adj = 0, m_str = 0, m_row = 0;
    logic [31:0] m_ctrl = '0, m_cfg = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_el = 0; m_ctrl = '0; m_cfg = '0; m_row = 0;
        end else begin
            was_busy = m_busy;
            if (m_busy) begin
                m_el++;
                if (m_el == m_adj + 5 + m_str) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end
            if (reg_wen && reg_addr == 6'd0 && !was_busy) begin
                m_ctrl = reg_wdata;
                if (reg_wdata[0]) begin
                    m_busy = 1; m_el = 0; m_done = 0;
                    m_adj = int'(m_cfg[23:20]);
                    m_str = int'(m_cfg[19:16]);
                    m_row = int'(reg_wdata[30:26]);
                end
            end else if (reg_wen && reg_addr == 6'd4) begin
                m_cfg = reg_wdata;
            end
            #2;
            chk(fuse_en == m_busy, "R3 fuse_en", 32'(fuse_en), 32'(m_busy));
            chk(fuse_strobe == (m_busy && m_el >= m_adj + 1), "R4 fuse_strobe",
                32'(fuse_strobe), 32'(m_busy && m_el >= m_adj + 1));
            chk(irq == (m_done && m_cfg[31]), "R8 irq", 32'(irq), 32'(m_done && m_cfg[31]));
            if (m_busy)
                chk(fuse_addr == 9'(m_row * 16), "R2 fuse_addr", 32'(fuse_addr), 32'(m_row * 16));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            reg_addr = 6'd8;
            #1;
            if (reg_rdata[0]) return;
        end
        chk(1'b0, "R5 done timeout", 32'd0, 32'd1);
    endtask

    task automatic chk_row(input int row, input string req);
        for (int w = 0; w < 8; w++) rd_chk(6'(12 + 4 * w), exp_word(row, w), req);
    endtask

    function automatic logic [31:0] cw(input int byte_addr, input bit go);
        return (32'(byte_addr) << 21) | (32'd31 << 16) | 32'(go);
    endfunction

    function automatic logic [31:0] cf(input int adj, input int str, input bit ie);
        return (32'(ie) << 31) | (32'(adj) << 20) | (32'(str) << 16);
    endfunction

    initial begin
        #1_000_000;
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 11; i++) rd_chk(6'(4 * i), 32'd0, "R1 reset reg");
        chk(!irq && !fuse_en && !fuse_strobe, "R1 outputs", {29'd0, irq, fuse_en, fuse_strobe}, 32'd0);

        // basic access, row 2
        wr(6'd4, cf(2, 3, 0));
        wr(6'd0, cw(10'h045, 1));
        rd_chk(6'd8, 32'd0, "R2 done cleared");
        wait_done();
        rd_chk(6'd8, 32'd1, "R9 status bit1 zero / R5 done");
        chk_row(2, "R5 row 2 data");

        // interrupt enable
        wr(6'd4, cf(2, 3, 1));
        chk(irq == 1'b1, "R8 irq set", 32'(irq), 32'd1);

        // control write without go
        wr(6'd0, cw(10'h3E0, 0) | 32'h0000_8002);
        rd_chk(6'd0, cw(10'h3E0, 0) | 32'h0000_8002, "R9 ctrl readback");
        rd_chk(6'd4, cf(2, 3, 1), "R9 cfg readback");
        rd_chk(6'd8, 32'd1, "R6 done held");
        chk_row(2, "R6 data held");

        // shortest timing, last row
        wr(6'd4, cf(0, 0, 0));
        wr(6'd0, cw(10'h3FF, 1));
        wait_done();
        chk_row(31, "R5 row 31 data");

        // longest timing with writes during access
        wr(6'd4, cf(15, 15, 0));
        wr(6'd0, cw(10'h000, 1));
        repeat (8) @(negedge clk);
        wr(6'd0, cw(10'h0A0, 1));
        wr(6'd4, cf(0, 0, 1));
        rd_chk(6'd0, cw(10'h000, 1), "R7 ctrl unchanged in access");
        wait_done();
        chk_row(0, "R7 R10 row 0 data");

        // control write on the completion edge
        wr(6'd4, cf(1, 1, 0));
        wr(6'd0, cw(10'h060, 1));
        repeat (5) @(negedge clk);
        wr(6'd0, cw(10'h120, 1));
        rd_chk(6'd0, cw(10'h060, 1), "R7 write on final edge ignored");
        rd_chk(6'd8, 32'd1, "R7 done after final edge");
        chk(fuse_en == 1'b0, "R7 no restart", 32'(fuse_en), 32'd0);
        chk_row(3, "R5 row 3 data");
        wr(6'd0, cw(10'h120, 1));
        rd_chk(6'd8, 32'd0, "R2 start after idle");
        wait_done();
        chk_row(9, "R5 row 9 data");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule